// File: doc/BRIEF.md
# Iterative Integer Divider

This block computes the quotient or the remainder of a signed or unsigned integer division, one quotient bit per clock cycle. A request is presented as a one-cycle `start` pulse together with the dividend, the divisor, a two-bit operation code and a word-mode flag. The block raises `done` for one cycle when `result` holds the answer. A `start` that arrives while an operation is still running is dropped.

In word mode only the low half of each operand is used. The half-width answer is then sign-extended to the full width, and this holds for the unsigned operations too. Two cases are resolved without iterating and without any trap: a zero divisor, and a signed division of the most negative value by minus one. Each returns a fixed, defined answer one cycle after it is accepted.

Signed operations divide the operand magnitudes and then correct the signs. Quotients truncate toward zero. The remainder takes the sign of the dividend.

Top module: `radix2_divider`

## Requirements
- R1: The operation code is 0 for signed quotient, 1 for unsigned quotient, 2 for signed remainder and 3 for unsigned remainder. For a non-zero divisor with no overflow, the full-width result is the truncated quotient or the matching remainder.
- R2: An unsigned quotient with a zero divisor returns all ones. An unsigned remainder with a zero divisor returns the dividend.
- R3: A signed quotient with a zero divisor returns minus one (all ones). A signed remainder with a zero divisor returns the dividend.
- R4: A signed quotient of the most negative value by minus one returns the most negative value.
- R5: A signed remainder of the most negative value by minus one returns zero.
- R6: For signed operations, the quotient is negative when the operand signs differ. The remainder carries the sign of the dividend.
- R7: With `word_mode` high, only bits 31:0 of each operand are used. Result bits 63:32 copy bit 31 for every operation, including the unsigned ones.
- R8: In word mode, a zero low-half divisor gives an unsigned remainder equal to the sign-extended low half of the dividend, and an unsigned quotient of all ones. The word-mode overflow case returns the sign-extended half-width most negative value as the quotient and zero as the remainder.
- R9: A zero-divisor or overflow request raises `done` in the cycle after the edge that accepts it. Any other request raises `done` 66 cycles after acceptance in full mode and 34 cycles after it in word mode. `done` lasts exactly one cycle.
- R10: A `start` seen while an operation is in progress is ignored. The running operation's result and timing are unchanged.
- R11: While `rst` is high, `done` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| op | input | 2 | 0 signed quotient, 1 unsigned quotient, 2 signed remainder, 3 unsigned remainder |
| word_mode | input | 1 | Use the low 32 bits and sign-extend the answer |
| dividend | input | 64 | Dividend operand |
| divisor | input | 64 | Divisor operand |
| result | output | 64 | Answer, valid while `done` is high and held afterwards |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted partial remainder or a wrong quotient bit inside the iteration core shows up only at the final `done` cycle, as a wrong `result`. The bench therefore compares every answer against a behavioural model and uses operands whose quotient and remainder both exercise many bits. A wrong iteration count or a lost state transition moves or removes the `done` pulse. Because `done` is compared on every cycle from acceptance onward, such a fault is caught in the cycle where it first differs. Sign-fixup faults appear only for mixed-sign operands, and word-mode alignment faults appear only in the upper half of `result`, so both kinds of operand are applied.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;

    typedef enum logic [1:0] {
        OP_SQUO = 2'd0,
        OP_UQUO = 2'd1,
        OP_SREM = 2'd2,
        OP_UREM = 2'd3
    } div_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    // Per-request control carried from acceptance to result fix-up
    typedef struct packed {
        logic want_rem;
        logic word;
        logic neg_quo;
        logic neg_rem;
    } div_ctl_t;

    function automatic logic op_signed(input div_op_e o);
        return (o == OP_SQUO) || (o == OP_SREM);
    endfunction

    function automatic logic op_rem(input div_op_e o);
        return (o == OP_SREM) || (o == OP_UREM);
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
`timescale 1ns/1ps
module div_operand_prep
    import div_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]      op,
    input  logic            word,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output div_ctl_t        ctl,
    output logic [XLEN-1:0] a_mag,
    output logic [XLEN-1:0] b_mag,
    output logic            special,
    output logic [XLEN-1:0] special_val
);
    localparam int HALF = XLEN / 2;

    div_op_e         op_e;
    logic            sgn;
    logic [HALF-1:0] a_lo, b_lo;
    logic [XLEN-1:0] a_sext, b_sext, a_ext, b_ext;
    logic            a_sb, b_sb, a_neg, b_neg;
    logic            zero_div, ovf;

    always_comb begin
        op_e   = div_op_e'(op);
        sgn    = op_signed(op_e);
        a_lo   = a[HALF-1:0];
        b_lo   = b[HALF-1:0];
        a_sext = {{HALF{a_lo[HALF-1]}}, a_lo};
        b_sext = {{HALF{b_lo[HALF-1]}}, b_lo};
        if (word) begin
            a_ext = sgn ? a_sext : {{HALF{1'b0}}, a_lo};
            b_ext = sgn ? b_sext : {{HALF{1'b0}}, b_lo};
            a_sb  = a_lo[HALF-1];
            b_sb  = b_lo[HALF-1];
        end else begin
            a_ext = a;
            b_ext = b;
            a_sb  = a[XLEN-1];
            b_sb  = b[XLEN-1];
        end
        a_neg = sgn & a_sb;
        b_neg = sgn & b_sb;
        a_mag = a_neg ? (XLEN'(0) - a_ext) : a_ext;
        b_mag = b_neg ? (XLEN'(0) - b_ext) : b_ext;

        zero_div = word ? (b_lo == '0) : (b == '0);
        if (word)
            ovf = sgn && (a_lo == {1'b1, {(HALF-1){1'b0}}}) && (b_lo == '1);
        else
            ovf = sgn && (a == {1'b1, {(XLEN-1){1'b0}}}) && (b == '1);
        special = zero_div | ovf;

        // The dividend, sign-extended in word mode, serves both special cases
        if (zero_div)
            special_val = op_rem(op_e) ? (word ? a_sext : a) : '1;
        else
            special_val = op_rem(op_e) ? '0 : (word ? a_sext : a);

        ctl.want_rem = op_rem(op_e);
        ctl.word     = word;
        ctl.neg_quo  = a_neg ^ b_neg;
        ctl.neg_rem  = a_neg;
    end
endmodule

// File: rtl/div_iter_core.sv
`timescale 1ns/1ps
module div_iter_core
    import div_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            word,
    input  logic [XLEN-1:0] a_mag,
    input  logic [XLEN-1:0] b_mag,
    output logic            busy,
    output logic            fix_cycle,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN + 1);

    div_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [XLEN-1:0] quo_q, rem_q, den_q;
    logic [XLEN:0]   shifted, diff;
    logic            take;

    always_comb begin
        shifted = {rem_q, quo_q[XLEN-1]};
        diff    = shifted - {1'b0, den_q};
        take    = ~diff[XLEN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            den_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        // Word operands are left-aligned so their top bit goes first
                        quo_q   <= word ? {a_mag[HALF-1:0], {HALF{1'b0}}} : a_mag;
                        rem_q   <= '0;
                        den_q   <= b_mag;
                        cnt_q   <= word ? CW'(HALF) : CW'(XLEN);
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    rem_q <= take ? diff[XLEN-1:0] : shifted[XLEN-1:0];
                    quo_q <= {quo_q[XLEN-2:0], take};
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1))
                        state_q <= ST_FIX;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign fix_cycle = (state_q == ST_FIX);
    assign quo       = quo_q;
    assign rem       = rem_q;
endmodule

// File: rtl/div_result_fix.sv
`timescale 1ns/1ps
module div_result_fix
    import div_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  div_ctl_t        ctl,
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] rem,
    output logic [XLEN-1:0] res
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] raw, val;
    logic            neg;

    always_comb begin
        raw = ctl.want_rem ? rem : quo;
        neg = ctl.want_rem ? ctl.neg_rem : ctl.neg_quo;
        if (ctl.word)
            raw = {{HALF{1'b0}}, raw[HALF-1:0]};
        val = neg ? (XLEN'(0) - raw) : raw;
        res = ctl.word ? {{HALF{val[HALF-1]}}, val[HALF-1:0]} : val;
    end
endmodule

// File: rtl/radix2_divider.sv
`timescale 1ns/1ps
module radix2_divider
    import div_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic            word_mode,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] result,
    output logic            done
);
    div_ctl_t        ctl_in, ctl_q;
    logic [XLEN-1:0] a_mag, b_mag, special_val, quo, rem, fixed;
    logic            special, busy_w, fix_cycle, accept;

    div_operand_prep #(.XLEN(XLEN)) prep_i (
        .op          (op),
        .word        (word_mode),
        .a           (dividend),
        .b           (divisor),
        .ctl         (ctl_in),
        .a_mag       (a_mag),
        .b_mag       (b_mag),
        .special     (special),
        .special_val (special_val)
    );

    assign accept = start & ~busy_w;

    div_iter_core #(.XLEN(XLEN)) core_i (
        .clk       (clk),
        .rst       (rst),
        .load      (accept & ~special),
        .word      (word_mode),
        .a_mag     (a_mag),
        .b_mag     (b_mag),
        .busy      (busy_w),
        .fix_cycle (fix_cycle),
        .quo       (quo),
        .rem       (rem)
    );

    div_result_fix #(.XLEN(XLEN)) fix_i (
        .ctl (ctl_q),
        .quo (quo),
        .rem (rem),
        .res (fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept)
                ctl_q <= ctl_in;
            if (accept && special) begin
                result <= special_val;
                done   <= 1'b1;
            end else if (fix_cycle) begin
                result <= fixed;
                done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/div_checker.sv
`timescale 1ns/1ps
module div_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [1:0]      op,
    input logic            word_mode,
    input logic [XLEN-1:0] dividend,
    input logic [XLEN-1:0] divisor,
    input logic [XLEN-1:0] result,
    input logic            done,
    input logic            busy
);
    localparam int HALF = XLEN / 2;
    localparam int TW   = $clog2(XLEN + 4) + 1;
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic          acc, acc_word;
    logic [TW-1:0] age;

    assign acc = start & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_word <= 1'b0;
            age      <= '0;
        end else if (acc) begin
            acc_word <= word_mode;
            age      <= TW'(1);
        end else if (age != '0 && age != '1) begin
            age <= age + 1'b1;
        end
    end

    AST_UQUO_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc && op == 2'd1 && !word_mode && divisor == '0 |=> done && result == '1); // R2

    AST_SQUO_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc && op == 2'd0 && !word_mode && divisor == '0 |=> done && result == '1); // R3

    AST_OVF_QUOTIENT: assert property (@(posedge clk) disable iff (rst)
        acc && op == 2'd0 && !word_mode && dividend == MOST_NEG && divisor == '1
        |=> done && result == MOST_NEG); // R4

    AST_OVF_REMAINDER: assert property (@(posedge clk) disable iff (rst)
        acc && op == 2'd2 && !word_mode && dividend == MOST_NEG && divisor == '1
        |=> done && result == '0); // R5

    AST_WORD_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
        done && acc_word |-> result[XLEN-1:HALF] == {HALF{result[HALF-1]}}); // R7

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (age == TW'(1) || age == (acc_word ? TW'(HALF + 2) : TW'(XLEN + 2)))); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !done && result == '0); // R11
endmodule

bind radix2_divider div_checker #(.XLEN(XLEN)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op),
    .word_mode (word_mode),
    .dividend  (dividend),
    .divisor   (divisor),
    .result    (result),
    .done      (done),
    .busy      (busy_w)
);

// File: tb/radix2_divider_tb_top.sv
`timescale 1ns/1ps
module radix2_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        word_mode = 1'b0;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic [63:0] result;
    logic        done;

    int  vectors = 0;
    int  misses  = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    radix2_divider #(.XLEN(64)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .word_mode(word_mode),
        .dividend(dividend), .divisor(divisor), .result(result), .done(done)
    );

    function automatic bit is_special(input logic [1:0] o, input logic w,
                                      input logic [63:0] a, input logic [63:0] b);
        bit sg = (o == 2'd0 || o == 2'd2);
        if (w) return (b[31:0] == 0) || (sg && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF);
        return (b == 0) || (sg && a == 64'h8000_0000_0000_0000 && b == '1);
    endfunction

    function automatic logic [63:0] model(input logic [1:0] o, input logic w,
                                          input logic [63:0] a, input logic [63:0] b);
        bit uns = (o == 2'd1 || o == 2'd3);
        bit rm  = (o == 2'd2 || o == 2'd3);
        if (w) begin
            logic [31:0] x = a[31:0], y = b[31:0], r;
            if (y == 0) r = rm ? x : 32'hFFFF_FFFF;
            else if (!uns && x == 32'h8000_0000 && y == 32'hFFFF_FFFF) r = rm ? 32'h0 : x;
            else if (uns) r = rm ? x % y : x / y;
            else begin
                int sx = int'(x), sy = int'(y);
                r = rm ? 32'(sx % sy) : 32'(sx / sy);
            end
            return {{32{r[31]}}, r};
        end else begin
            if (b == 0) return rm ? a : '1;
            if (!uns && a == 64'h8000_0000_0000_0000 && b == '1) return rm ? 64'h0 : a;
            if (uns) return rm ? a % b : a / b;
            begin
                longint sx = longint'(a), sy = longint'(b);
                return rm ? 64'(sx % sy) : 64'(sx / sy);
            end
        end
    endfunction

    function automatic string tag_of(input logic [1:0] o, input logic w,
                                     input logic [63:0] a, input logic [63:0] b);
        bit uns = (o == 2'd1 || o == 2'd3);
        bit rm  = (o == 2'd2 || o == 2'd3);
        if (w && is_special(o, w, a, b)) return "R8";
        if (w) return "R7";
        if (b == 0) return uns ? "R2" : "R3";
        if (is_special(o, w, a, b)) return rm ? "R5" : "R4";
        if (!uns && (a[63] || b[63])) return "R6";
        return "R1";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Called at a negedge; drives a request and follows it to completion
    task automatic run_op(input logic [1:0] o, input logic w,
                          input logic [63:0] a, input logic [63:0] b, input bit poke);
        logic [63:0] exp = model(o, w, a, b);
        int          lat = is_special(o, w, a, b) ? 1 : ((w ? 32 : 64) + 2);
        string       tag = tag_of(o, w, a, b);
        start = 1'b1; op = o; word_mode = w; dividend = a; divisor = b;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (poke && k == 4) begin
                // R10: a request during a running operation must be dropped
                start = 1'b1; op = 2'd1; dividend = 64'd9; divisor = 64'd0;
            end
            if (poke && k == 5) start = 1'b0;
            if (k < lat) check(poke ? "R10" : "R9", "done early", {63'b0, done}, 64'd0);
            else begin
                check(poke ? "R10" : "R9", "done at completion", {63'b0, done}, 64'd1);
                check(poke ? "R10" : tag, "result", result, exp);
            end
        end
        @(negedge clk);
        check("R9", "done one-cycle pulse", {63'b0, done}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", "done in reset", {63'b0, done}, 64'd0);
        check("R11", "result in reset", result, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        run_op(2'd1, 0, 64'd100, 64'd7, 0);                          // R1
        run_op(2'd3, 0, 64'd100, 64'd7, 0);                          // R1
        run_op(2'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0);          // R1
        run_op(2'd3, 0, 64'hFEDC_BA98_7654_3210, 64'h1_0000_0001, 0); // R1
        run_op(2'd0, 0, -64'sd100, 64'd7, 0);                        // R6
        run_op(2'd2, 0, -64'sd100, 64'd7, 0);                        // R6
        run_op(2'd0, 0, 64'd100, -64'sd7, 0);                        // R6
        run_op(2'd2, 0, 64'd100, -64'sd7, 0);                        // R6
        run_op(2'd0, 0, -64'sd12345678901, -64'sd97, 0);             // R6
        run_op(2'd1, 0, 64'h1234, 64'd0, 0);                         // R2
        run_op(2'd3, 0, 64'h1234, 64'd0, 0);                         // R2
        run_op(2'd0, 0, -64'sd55, 64'd0, 0);                         // R3
        run_op(2'd2, 0, -64'sd55, 64'd0, 0);                         // R3
        run_op(2'd0, 0, 64'h8000_0000_0000_0000, '1, 0);             // R4
        run_op(2'd2, 0, 64'h8000_0000_0000_0000, '1, 0);             // R5
        run_op(2'd1, 1, 64'hDEAD_BEEF_FFFF_FFFE, 64'h1234_0000_0001, 0); // R7
        run_op(2'd0, 1, 64'h0123_4567_FFFF_FFF9, 64'hABCD_0000_0000_0002, 0); // R7
        run_op(2'd2, 1, 64'h0123_4567_FFFF_FFF9, 64'hABCD_0000_0000_0002, 0); // R7
        run_op(2'd3, 1, 64'h0000_0001_9000_0000, 64'h0000_0000_0000_0007, 0); // R7
        run_op(2'd3, 1, 64'h5555_5555_8000_0001, 64'h7777_7777_0000_0000, 0); // R8
        run_op(2'd1, 1, 64'h5555_5555_8000_0001, 64'h7777_7777_0000_0000, 0); // R8
        run_op(2'd0, 1, 64'h1111_1111_8000_0000, 64'h2222_2222_FFFF_FFFF, 0); // R8
        run_op(2'd2, 1, 64'h1111_1111_8000_0000, 64'h2222_2222_FFFF_FFFF, 0); // R8
        run_op(2'd1, 0, 64'd1_000_000_007, 64'd13, 1);               // R10

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule